// File: doc/BRIEF.md
# Single-Cycle Integer Core (Load/Store, Arithmetic, Branch, Jump Subset)

This block is a 32-bit processor core that finishes one instruction in each clock cycle. It holds the program counter, a 32-entry general register file, an arithmetic/logic unit and two decoders. The main decoder turns the 6-bit opcode into datapath controls and a 2-bit ALU mode. The second decoder turns that mode, and for register-to-register instructions the function field too, into a 4-bit ALU operation code. The next program counter comes from one of three sources: the sequential address, a relative branch target or an absolute jump target.

Instruction memory and data memory are outside the core. Both are read combinationally from the addresses the core drives. The data memory takes a write at the rising clock edge when the core asserts its store enable. The instruction formats follow the common 32-bit three-register layout: opcode in bits 31:26, source registers in 25:21 and 20:16, destination in 15:11, function code in 5:0, a 16-bit immediate in 15:0 and a 26-bit jump field in 25:0.

Top module: `core_sc`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge sets the program counter (`imem_addr`) to 0.
- R2: Any instruction that is neither a jump nor a taken branch advances `imem_addr` by 4 at the next edge. Exactly one instruction completes per cycle.
- R3: Load (opcode 35) and store (opcode 43) drive `dmem_addr` = register[bits 25:21] + sign-extended bits 15:0. An add is used whatever the low 6 bits of the immediate hold. A load writes the read data into register[bits 20:16]. A store asserts `dmem_we` and drives register[bits 20:16] on `dmem_wdata`.
- R4: Opcode 0 writes register[bits 15:11] with the result selected by funct: 100000 add, 100010 subtract, 100100 AND, 100101 OR.
- R5: Funct 101010 with opcode 0 writes 1 when register[25:21] is less than register[20:16] as signed two's complement numbers, and 0 otherwise.
- R6: Branch-if-equal (opcode 4) compares by subtraction. When the two registers are equal, the next PC is PC+4 + (sign-extended imm << 2); otherwise it is PC+4. The low 6 bits of the immediate do not change the operation.
- R7: Jump (opcode 2) loads the PC with {PC+4[31:28], bits 25:0, 2'b00}. Jump takes priority over the branch/sequential choice.
- R8: Register 0 always reads as 0, and writes to it are discarded.
- R9: Only opcode 0 and loads write the register file. Stores, branches and jumps leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word read at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, taken at the next rising edge |
| dmem_rdata | input | 32 | Load data read at `dmem_addr` |

## Verification
The only views of this core from outside are the PC on `imem_addr` and the store traffic. A corrupted register or a wrong ALU code therefore stays hidden until a later store writes that register out, or a branch depends on it. The test program stores every result right after computing it, so a bad value appears in the next cycle's store data. It also stores two registers a second time after a branch and a store, to catch writes that should not have happened. A wrong PC update shows at `imem_addr` one cycle after the instruction that caused it, and the bench checks the PC every cycle.

// File: rtl/core_pkg.sv
// Package: shared encodings and the control word of the single-cycle core.
// Assumes the fixed 32-bit instruction format (opcode 31:26, funct 5:0).
package core_pkg;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_JMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_LOAD = 6'd35;
    localparam logic [5:0] OPC_STOR = 6'd43;

    // ALU operation codes (4 bits, six used)
    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    // Mode handed from main decoder to ALU decoder
    typedef enum logic [1:0] {
        AM_ADD   = 2'b00,
        AM_SUB   = 2'b01,
        AM_FUNCT = 2'b10
    } alu_mode_e;

    typedef struct packed {
        logic      rf_we;      // write register file
        logic      dst_rd;     // destination is bits 15:11 (else 20:16)
        logic      src_imm;    // ALU B operand is the immediate
        logic      mem_we;     // store
        logic      mem_to_rf;  // write-back from data memory
        logic      is_branch;  // branch-if-equal
        logic      is_jump;    // absolute jump
        alu_mode_e mode;
    } ctrl_t;

endpackage

// File: rtl/ctl_main.sv
// Main decoder: maps the 6-bit opcode to the datapath control word.
// Assumes unknown opcodes behave as no-operations (no writes, sequential PC).
module ctl_main
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Decode one opcode into the full control word
    always_comb begin
        ctrl = '{default: '0, mode: AM_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.rf_we  = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.mode   = AM_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.rf_we     = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.mem_to_rf = 1'b1;
            end
            OPC_STOR: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.mode      = AM_SUB;
            end
            OPC_JMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_alu.sv
// ALU decoder: second decode level from mode and funct to a 4-bit ALU code.
// Assumes the top two funct bits carry no information for the supported set.
module ctl_alu
    import core_pkg::*;
(
    input  alu_mode_e mode,
    input  logic [5:0] funct,
    output alu_op_e    op
);

    // Select a fixed operation or decode the function field
    always_comb begin
        case (mode)
            AM_ADD: op = ALU_ADD;
            AM_SUB: op = ALU_SUB;
            default: begin
                casez (funct)
                    6'b??0000: op = ALU_ADD;
                    6'b??0010: op = ALU_SUB;
                    6'b??0100: op = ALU_AND;
                    6'b??0101: op = ALU_OR;
                    6'b??1010: op = ALU_SLT;
                    default:   op = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/core_alu.sv
// Arithmetic/logic unit with a zero flag; set-on-less-than is signed.
// Assumes op is one of the six defined codes; others give zero.
module core_alu
    import core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Compute the result for the selected operation
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/core_rf.sv
// Register file: two combinational read ports, one synchronous write port.
// Assumes entry 0 is hard-wired to zero; all entries clear on reset.
module core_rf #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N];

    // Clear on reset; otherwise write any entry except zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R8
    r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rd_a == '0));

endmodule

// File: rtl/core_sc.sv
// Single-cycle core top: PC register, decoders, register file, ALU and
// next-PC selection. Assumes combinational instruction and data reads and a
// data write taken by the memory at the rising edge while dmem_we is high.
module core_sc
    import core_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int AW    = $clog2(NREG);
    localparam int IMM_W = 16;

    logic [XLEN-1:0] pc_q, pc_nxt, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data;
    logic [AW-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
    logic            alu_zero;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic            unused_shamt;

    assign rs_idx       = imem_data[21 +: AW];
    assign rt_idx       = imem_data[16 +: AW];
    assign rd_idx       = imem_data[11 +: AW];
    assign unused_shamt = ^imem_data[10:6];
    assign imm_ext      = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

    ctl_main u_main (.opcode(imem_data[31:26]), .ctrl(ctrl));

    ctl_alu u_aluctl (.mode(ctrl.mode), .funct(imem_data[5:0]), .op(alu_op));

    core_rf #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(rs_idx), .ra_b(rt_idx), .rd_a(rs_val), .rd_b(rt_val),
        .we(ctrl.rf_we), .wa(wr_idx), .wd(wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    core_alu #(.W(XLEN)) u_alu (
        .a(rs_val), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero)
    );

    assign wr_idx  = ctrl.dst_rd ? rd_idx : rt_idx;
    assign wb_data = ctrl.mem_to_rf ? dmem_rdata : alu_y;

    // Next-PC candidates and selection; jump overrides branch/sequential
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + (imm_ext << 2);
    assign jmp_target = {pc_plus4[XLEN-1:28], imem_data[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jump)                    pc_nxt = jmp_target;
        else if (ctrl.is_branch && alu_zero) pc_nxt = br_target;
        else                                 pc_nxt = pc_plus4;
    end

    // Program counter register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    // R1
    pc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_q == '0));

    // R2
    pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.is_jump && !ctrl.is_branch) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R7
    jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[31:26] == OPC_JMP) |=>
            (pc_q[1:0] == 2'b00 && pc_q[27:2] == $past(imem_data[25:0])));

    // R6
    br_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[31:26] == OPC_BEQ && rs_val == rt_val) |=>
            (pc_q == $past(pc_q) + XLEN'(4) + ($past(imm_ext) << 2)));

    // R3
    mem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[31:26] == OPC_STOR || imem_data[31:26] == OPC_LOAD) |->
            (dmem_addr == rs_val + imm_ext));

    // R9
    rf_we_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.rf_we |-> (imem_data[31:26] == OPC_REG || imem_data[31:26] == OPC_LOAD));

endmodule

// File: tb/sim_core_sc.sv
// Scoreboard bench: a driver task queues the expected PC and store traffic
// for every cycle of a fixed program; a monitor pops and compares them.
module sim_core_sc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] im [64];
    logic [31:0] dm [64];

    always #10 clk = ~clk;

    core_sc u0 (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = im[imem_addr[7:2]];
    assign dmem_rdata = dm[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

    typedef struct {
        logic [31:0] pc;
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;

    exp_t  q  [$];
    string tq [$];
    int    n_chk = 0, n_bad = 0;
    bit    run = 0, mon_done = 0;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: queue one expected cycle
    task automatic push(logic [31:0] pc, bit we, logic [31:0] a, logic [31:0] d, string tag);
        exp_t e;
        e.pc = pc; e.we = we; e.addr = a; e.data = d;
        q.push_back(e);
        tq.push_back(tag);
    endtask

    // Monitor: compare one queued item per cycle, sampled after the falling edge
    initial begin
        wait (run);
        while (q.size() > 0) begin
            exp_t  e;
            string t;
            #1;
            e = q.pop_front();
            t = tq.pop_front();
            chk(imem_addr == e.pc, t, "pc", imem_addr, e.pc);
            chk(dmem_we == e.we, t, "store enable", 32'(dmem_we), 32'(e.we));
            if (e.we) begin
                chk(dmem_addr == e.addr, t, "store addr", dmem_addr, e.addr);
                chk(dmem_wdata == e.data, t, "store data", dmem_wdata, e.data);
            end
            @(negedge clk);
        end
        mon_done = 1;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R2 run hung actual=%h expected=done", imem_addr);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            im[i] = enc_i(43, 0, 2, 16'd52);   // filler store: marks a wrong path
            dm[i] = 32'h0;
        end
        dm[0] = 32'd5; dm[1] = 32'hFFFF_FFFD; dm[2] = 32'd7;
        im[0]  = enc_i(35, 0, 1, 16'd0);        // lw r1
        im[1]  = enc_i(35, 0, 2, 16'd4);        // lw r2
        im[2]  = enc_i(35, 0, 3, 16'd8);        // lw r3 (imm low bits 001000)
        im[3]  = enc_r(1, 3, 4, 6'h20);         // add
        im[4]  = enc_i(43, 0, 4, 16'd16);
        im[5]  = enc_r(1, 3, 5, 6'h22);         // sub
        im[6]  = enc_i(43, 0, 5, 16'd20);
        im[7]  = enc_r(1, 3, 6, 6'h24);         // and
        im[8]  = enc_i(43, 0, 6, 16'd24);
        im[9]  = enc_r(1, 2, 7, 6'h25);         // or
        im[10] = enc_i(43, 0, 7, 16'd28);
        im[11] = enc_r(2, 1, 8, 6'h2A);         // slt -3 < 5
        im[12] = enc_i(43, 0, 8, 16'd32);
        im[13] = enc_r(1, 2, 9, 6'h2A);         // slt 5 < -3
        im[14] = enc_i(43, 0, 9, 16'd36);
        im[15] = enc_r(1, 1, 0, 6'h20);         // write r0
        im[16] = enc_i(43, 0, 0, 16'd40);
        im[17] = enc_i(4, 1, 3, 16'h0024);      // beq not taken
        im[18] = enc_i(4, 1, 6, 16'h0024);      // beq taken -> 0xDC
        im[24] = enc_i(4, 0, 0, 16'hFFFF);      // self loop at 0x60
        im[55] = enc_i(43, 0, 6, 16'd44);       // 0xDC
        im[56] = enc_i(43, 0, 4, 16'd48);       // 0xE0
        im[57] = {6'd2, 26'd24};                // 0xE4: j 0x60

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(imem_addr == 32'h0, "R1", "pc in reset", imem_addr, 32'h0);

        push(32'h00, 0, 0, 0, "R3 load");
        push(32'h04, 0, 0, 0, "R3 load");
        push(32'h08, 0, 0, 0, "R3 load funct-ignored");
        push(32'h0C, 0, 0, 0, "R2");
        push(32'h10, 1, 32'd16, 32'd12, "R4 add / R3 store");
        push(32'h14, 0, 0, 0, "R2");
        push(32'h18, 1, 32'd20, 32'hFFFF_FFFE, "R4 sub");
        push(32'h1C, 0, 0, 0, "R2");
        push(32'h20, 1, 32'd24, 32'd5, "R4 and");
        push(32'h24, 0, 0, 0, "R2");
        push(32'h28, 1, 32'd28, 32'hFFFF_FFFD, "R4 or");
        push(32'h2C, 0, 0, 0, "R2");
        push(32'h30, 1, 32'd32, 32'd1, "R5 signed less");
        push(32'h34, 0, 0, 0, "R2");
        push(32'h38, 1, 32'd36, 32'd0, "R5 signed not less");
        push(32'h3C, 0, 0, 0, "R2");
        push(32'h40, 1, 32'd40, 32'd0, "R8 r0 stays zero");
        push(32'h44, 0, 0, 0, "R6 beq");
        push(32'h48, 0, 0, 0, "R6 not taken");
        push(32'hDC, 1, 32'd44, 32'd5, "R6 taken / R9 beq no write");
        push(32'hE0, 1, 32'd48, 32'd12, "R9 store no write");
        push(32'hE4, 0, 0, 0, "R2");
        push(32'h60, 0, 0, 0, "R7 jump target");
        push(32'h60, 0, 0, 0, "R6 backward branch");
        push(32'h60, 0, 0, 0, "R6 backward branch");

        rst_n = 1'b1;
        run   = 1;
        wait (mon_done);

        // Reset again in the middle of the loop
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk(imem_addr == 32'h0, "R1", "pc after mid-run reset", imem_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(imem_addr == 32'h4, "R2", "pc after restart", imem_addr, 32'h4);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule